// File: doc/BRIEF.md
# Push-Pull PWM Modulator with Soft-Start

This block generates the two gate-drive phases of a push-pull or half-bridge converter from a single system clock. A counter oscillator divides the clock down to the switching rate (65 kHz with the default parameters). The two active-low outputs take turns, one pulse per oscillator period. Each pulse starts at the beginning of its period and ends when the ramp count reaches the effective duty. A termination latch then holds the pulse off until the period ends.

The effective duty is the smallest of three values: the loop duty command (which stands in for the error amplifier and comparator), a soft-start value that climbs from zero after every start, and a fixed on-time cap. The cap is just under the full period, so each output gets just under half of its own two-period cycle and there is always dead time between the phases. A fault input or a low run-enable input stops switching at once, clears the soft-start value and resets the phase steering. A later restart therefore begins gently and on a known phase.

Top module: `pushpull_pwm`

## Requirements
- R1: After reset, both outputs are high, which is the inactive level.
- R2: The oscillator period is PERIOD = CLK_HZ/SW_HZ clocks (100 with the defaults). In steady operation a new pulse begins every PERIOD clocks.
- R3: The outputs alternate. `drvA_n` serves the even periods counted from enable and `drvB_n` the odd ones, and the two are never low at the same time.
- R4: An output goes low one clock after its period starts and stays low for exactly effDuty clocks, where effDuty = min(dutyCmd, soft-start value, MAX_ON).
- R5: No pulse is longer than MAX_ON = PERIOD*MAX_PCT/100 clocks (93 with the defaults), even when dutyCmd is larger.
- R6: Once the ramp count reaches effDuty, the active output stays high for the rest of that period. This holds even if dutyCmd rises again before the period ends.
- R7: The soft-start value is 0 in the first period after enable. It grows by SS_STEP (8) at each period boundary and is clamped at SS_CEIL (96).
- R8: While `fault` is 1 or `runEn` is 0, both outputs are high from the next clock edge and the soft-start value is zero. When the block runs again, it restarts with period 0 on `drvA_n` and soft-start at 0.
- R9: A dutyCmd of zero produces no pulse on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | 1 allows switching; 0 is an off request |
| fault | input | 1 | 1 forces drive off and clears soft-start |
| dutyCmd | input | DUTY_W | Loop duty command, in clocks of on-time per period |
| drvA_n | output | 1 | Phase A drive, active low |
| drvB_n | output | 1 | Phase B drive, active low |

## Verification
Both drive outputs are registered, so the level for a given ramp count appears one clock after the edge that sees that count. A halt request is therefore visible at the edge after it is applied. A soft-start step takes effect from the first count of the following period. The bench model advances on every rising edge using the same inputs the design sees, and pushes the drive pair expected after that edge into a queue. A monitor pops each entry at the next falling edge and compares it there. Directed checks of pulse width, pulse spacing, the latch hold and the fault response also sample on falling edges, and they count cycles from a rising-edge counter.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int NUM_PH = 2;

  typedef struct packed {
    logic running;      // drive permitted this cycle
    logic periodStart;  // ramp count is zero
    logic periodEnd;    // last count of the period
    logic phase;        // steering: 0 selects drive A
  } pwm_strobe_t;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int PERIOD  = 100,
  parameter int DUTY_W  = 8,
  parameter int SS_STEP = 8,
  parameter int SS_CEIL = 96,
  localparam int CNT_W  = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              runEn,
  input  logic              fault,
  output pwm_strobe_t       strb,
  output logic [CNT_W-1:0]  cnt,
  output logic [DUTY_W-1:0] ssVal
);

  localparam int SUM_W = DUTY_W + 1;

  logic             halt;
  logic             lastCnt;
  logic             phaseQ;
  logic [SUM_W-1:0] ssSum;
  logic [DUTY_W-1:0] ssNext;

  assign halt    = fault | ~runEn;
  assign lastCnt = (cnt == CNT_W'(PERIOD - 1));

  // soft-start increment with ceiling clamp
  always_comb begin
    ssSum = {1'b0, ssVal} + SUM_W'(SS_STEP);
    if (ssSum > SUM_W'(SS_CEIL)) ssNext = DUTY_W'(SS_CEIL);
    else                         ssNext = ssSum[DUTY_W-1:0];
  end

  // oscillator counter, steering flip-flop and soft-start register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
      ssVal  <= '0;
    end else if (halt) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
      ssVal  <= '0;
    end else if (lastCnt) begin
      cnt    <= '0;
      phaseQ <= ~phaseQ;
      ssVal  <= ssNext;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  always_comb begin
    strb.running     = ~halt;
    strb.periodStart = ~halt & (cnt == '0);
    strb.periodEnd   = ~halt & lastCnt;
    strb.phase       = phaseQ;
  end

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int DUTY_W = 8,
  parameter int MAX_ON = 93
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwm_strobe_t       strb,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DUTY_W-1:0] dutyCmd,
  input  logic [DUTY_W-1:0] ssVal,
  output logic [NUM_PH-1:0] drvN
);

  localparam int CMP_W = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;

  logic [CMP_W-1:0] cntX, dutyX, ssX, capX, effDuty;
  logic             trip;
  logic             termLatch;
  logic             onNext;

  assign cntX  = CMP_W'(cnt);
  assign dutyX = CMP_W'(dutyCmd);
  assign ssX   = CMP_W'(ssVal);
  assign capX  = CMP_W'(MAX_ON);

  // smallest of command, soft-start and on-time cap
  always_comb begin
    effDuty = dutyX;
    if (ssX < effDuty)  effDuty = ssX;
    if (capX < effDuty) effDuty = capX;
  end

  assign trip = (cntX >= effDuty);

  // cycle-by-cycle termination latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 termLatch <= 1'b0;
    else if (!strb.running)     termLatch <= 1'b0;
    else if (strb.periodEnd)    termLatch <= 1'b0;
    else if (trip)              termLatch <= 1'b1;
  end

  assign onNext = strb.running & (strb.periodStart | ~termLatch) & ~trip;

  // one registered active-low driver per phase
  for (genvar g = 0; g < NUM_PH; g++) begin : g_drv
    logic drvQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drvQ <= 1'b1;
      else        drvQ <= ~(onNext && (strb.phase == 1'(g)));
    end
    assign drvN[g] = drvQ;
  end

endmodule

// File: rtl/pushpull_pwm.sv
module pushpull_pwm
  import pwm_pkg::*;
#(
  parameter int CLK_HZ  = 6_500_000,
  parameter int SW_HZ   = 65_000,
  parameter int DUTY_W  = 8,
  parameter int MAX_PCT = 93,
  parameter int SS_STEP = 8,
  parameter int SS_CEIL = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              runEn,
  input  logic              fault,
  input  logic [DUTY_W-1:0] dutyCmd,
  output logic              drvA_n,
  output logic              drvB_n
);

  localparam int PERIOD = CLK_HZ / SW_HZ;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam int MAX_ON = PERIOD * MAX_PCT / 100;

  pwm_strobe_t       strb;
  logic [CNT_W-1:0]  cnt;
  logic [DUTY_W-1:0] ssVal;
  logic [NUM_PH-1:0] drvN;
  logic              cycStart;
  logic              haltReq;

  pwm_ctrl #(
    .PERIOD (PERIOD),
    .DUTY_W (DUTY_W),
    .SS_STEP(SS_STEP),
    .SS_CEIL(SS_CEIL)
  ) uCtrl (
    .clk  (clk),
    .rst_n(rst_n),
    .runEn(runEn),
    .fault(fault),
    .strb (strb),
    .cnt  (cnt),
    .ssVal(ssVal)
  );

  pwm_datapath #(
    .CNT_W (CNT_W),
    .DUTY_W(DUTY_W),
    .MAX_ON(MAX_ON)
  ) uPath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .cnt    (cnt),
    .dutyCmd(dutyCmd),
    .ssVal  (ssVal),
    .drvN   (drvN)
  );

  assign drvA_n   = drvN[0];
  assign drvB_n   = drvN[1];
  assign cycStart = strb.periodStart;
  assign haltReq  = ~strb.running;

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int MAX_ON  = 93,
  parameter int DUTY_W  = 8,
  parameter int SS_CEIL = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drvA_n,
  input logic              drvB_n,
  input logic              cycStart,
  input logic              haltReq,
  input logic [DUTY_W-1:0] ssVal
);

  localparam int RUN_W = $clog2(MAX_ON + 2) + 1;

  logic [RUN_W-1:0] onRun;

  // length of the current low run on either output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 onRun <= '0;
    else if (drvA_n && drvB_n)  onRun <= '0;
    else if (onRun != '1)       onRun <= onRun + 1'b1;
  end

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!drvA_n && !drvB_n));

  p_halt_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    haltReq |=> (drvA_n && drvB_n));

  p_ss_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    haltReq |=> (ssVal == '0));

  p_start_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drvA_n) || $fell(drvB_n)) |-> $past(cycStart));

  p_width_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    onRun <= RUN_W'(MAX_ON));

  p_ss_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ssVal <= DUTY_W'(SS_CEIL));

endmodule

bind pushpull_pwm pwm_checker #(
  .MAX_ON (MAX_ON),
  .DUTY_W (DUTY_W),
  .SS_CEIL(SS_CEIL)
) uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .drvA_n  (drvA_n),
  .drvB_n  (drvB_n),
  .cycStart(cycStart),
  .haltReq (haltReq),
  .ssVal   (ssVal)
);

// File: tb/tb_pushpull_pwm.sv
module tb_pushpull_pwm;

  localparam int CLK_PERIOD = 10;
  localparam int PER    = 100;
  localparam int MAXON  = 93;
  localparam int STEP   = 8;
  localparam int CEIL   = 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       runEn = 1'b0;
  logic       fault = 1'b0;
  logic [7:0] dutyCmd = 8'd0;
  logic       drvA_n, drvB_n;

  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  string curReq = "R1";
  logic [1:0] qExp[$];

  // reference state advanced from the requirements
  int mCnt = 0, mPh = 0, mSs = 0, mLat = 0;

  pushpull_pwm #(
    .CLK_HZ(6_500_000), .SW_HZ(65_000), .DUTY_W(8),
    .MAX_PCT(93), .SS_STEP(STEP), .SS_CEIL(CEIL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .fault(fault),
    .dutyCmd(dutyCmd), .drvA_n(drvA_n), .drvB_n(drvB_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected drive pair after each edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mCnt = 0; mPh = 0; mSs = 0; mLat = 0;
    end else if (fault || !runEn) begin
      mCnt = 0; mPh = 0; mSs = 0; mLat = 0;
      qExp.push_back(2'b11);
    end else begin
      int eff;
      bit on;
      eff = dutyCmd;
      if (mSs < eff)   eff = mSs;
      if (MAXON < eff) eff = MAXON;
      on = (mLat == 0) && (mCnt < eff);
      qExp.push_back({~(on && mPh == 1), ~(on && mPh == 0)});
      if (mCnt >= eff) mLat = 1;
      if (mCnt == PER - 1) begin
        mCnt = 0; mPh ^= 1; mLat = 0;
        mSs = (mSs + STEP > CEIL) ? CEIL : mSs + STEP;
      end else mCnt++;
    end
  end

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (qExp.size() > 0) begin
      logic [1:0] e;
      e = qExp.pop_front();
      chk({drvB_n, drvA_n} == e, curReq, {drvB_n, drvA_n}, e);
    end
  end

  task automatic waitCnt(int c);
    do @(negedge clk); while (mCnt != c);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired (run hung)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tA, tB, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(drvA_n === 1'b1 && drvB_n === 1'b1, "R1", {drvB_n, drvA_n}, 3);

    // R7: soft-start ramp from enable
    curReq = "R7";
    dutyCmd = 8'd50;
    runEn = 1'b1;
    w = 0;
    repeat (PER) begin @(negedge clk); if (!drvA_n || !drvB_n) w++; end
    chk(w == 0, "R7 first period silent", w, 0);
    w = 0;
    while (drvB_n !== 1'b0) @(negedge clk);
    while (drvB_n === 1'b0) begin w++; @(negedge clk); end
    chk(w == STEP, "R7 second period width", w, STEP);
    repeat (10 * PER) @(negedge clk);

    // R2, R3, R4: steady operation
    curReq = "R4";
    while (drvA_n !== 1'b0) @(negedge clk);
    tA = cyc; w = 0;
    while (drvA_n === 1'b0) begin w++; @(negedge clk); end
    chk(w == 50, "R4 width", w, 50);
    while (drvB_n !== 1'b0) @(negedge clk);
    tB = cyc;
    chk(tB - tA == PER, "R2 pulse spacing", tB - tA, PER);
    while (drvA_n !== 1'b0) @(negedge clk);
    chk(cyc - tB == PER, "R3 alternation", cyc - tB, PER);

    // R5: command above the on-time cap
    curReq = "R5";
    dutyCmd = 8'd200;
    repeat (2 * PER) @(negedge clk);
    while (drvA_n !== 1'b0) @(negedge clk);
    w = 0;
    while (drvA_n === 1'b0) begin w++; @(negedge clk); end
    chk(w == MAXON, "R5 capped width", w, MAXON);
    w = 0;
    while (drvB_n !== 1'b0) begin w++; @(negedge clk); end
    chk(w == PER - MAXON, "R5 dead time", w, PER - MAXON);

    // R6: command dips below the count then recovers within the period
    curReq = "R6";
    dutyCmd = 8'd60;
    waitCnt(40);
    dutyCmd = 8'd20;
    repeat (2) @(negedge clk);
    dutyCmd = 8'd60;
    w = 0;
    repeat (PER - 45) begin @(negedge clk); if (!drvA_n || !drvB_n) w++; end
    chk(w == 0, "R6 no retrigger", w, 0);

    // R9: zero command
    curReq = "R9";
    waitCnt(PER - 1);
    dutyCmd = 8'd0;
    w = 0;
    repeat (3 * PER) begin @(negedge clk); if (!drvA_n || !drvB_n) w++; end
    chk(w == 0, "R9 no pulse", w, 0);

    // R8: fault during a pulse, then restart
    curReq = "R8";
    dutyCmd = 8'd60;
    repeat (PER) @(negedge clk);
    waitCnt(10);
    fault = 1'b1;
    @(negedge clk);
    chk(drvA_n === 1'b1 && drvB_n === 1'b1, "R8 fault off", {drvB_n, drvA_n}, 3);
    repeat (20) @(negedge clk);
    fault = 1'b0;
    while (drvA_n === 1'b1 && drvB_n === 1'b1) @(negedge clk);
    chk(drvB_n === 1'b0, "R8 restart phase", drvB_n, 0);
    w = 0;
    while (drvB_n === 1'b0) begin w++; @(negedge clk); end
    chk(w == STEP, "R8 soft restart", w, STEP);
    while (drvA_n !== 1'b0) @(negedge clk);
    runEn = 1'b0;
    @(negedge clk);
    chk(drvA_n === 1'b1 && drvB_n === 1'b1, "R8 off request", {drvB_n, drvA_n}, 3);
    repeat (5) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule